// File: doc/BRIEF.md
# Regulator Power-Up Sequencer

This block is the digital controller that brings up a small power tree. The tree has three regulators: two step-down converters (buck A and buck B) and one linear regulator. Each regulator has one enable output. An automatic bring-up starts in one of two ways: on a rising edge of the enable pin, or when the host sets the start bit in the control register. The block then waits for a start-up interval, counted in millisecond ticks. It then turns the regulators on one at a time, in the order given by static fuse inputs. After each regulator it waits for that regulator's power-good signal, then waits a fixed gap, and only then moves to the next slot.

Power-good inputs pass through a two-flop synchronizer. The combined run output `shdn_n` is high only when every regulator that is not masked reports power good. The masks come from fuse inputs until the host writes the operational-control register; from then on the written value replaces the fuse masks.

The host can also drive the enables directly. Writing the control register with the start bit clear sets the enables from the written bits and cancels any sequence that is in progress.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After a start, no enable rises before `STARTUP_TICKS` (default 5) ticks of `ms_tick`. The regulator in the first slot is enabled within three clocks of the tick that completes the count.
- R2: Slot k, for k = 0, 1, 2, takes its regulator code from `fuse_order[2k+1:2k]`. Code 0 is buck A, code 1 is buck B, code 2 is the linear regulator, and code 3 marks an empty slot. Enable bit 0 is buck A, bit 1 is buck B and bit 2 is the linear regulator.
- R3: The next slot is not enabled until the synchronized power-good of the regulator just enabled is high. The gap is counted from that point: `GAP1_TICKS` (default 2) ticks after slot 0 and `GAP2_TICKS` (default 3) ticks after slot 1. At most one enable rises per clock.
- R4: A regulator whose `fuse_unused` bit is set is never enabled by the sequence, and an empty slot is handled the same way. Either kind of slot adds no wait: the next used regulator follows the gap that was already served.
- R5: A sequence starts on a rising edge of `en_pin`, or on a write to address 0x03 with bit 4 set while bit 4 reads 0. The register start sets bit 4. A further write with bit 4 set while it is already set changes nothing.
- R6: A falling edge of `en_pin` clears all enables on the next clock. It also ends the sequence and clears bit 4.
- R7: A write to address 0x03 with bit 4 clear ends any sequence, clears bit 4, and sets the enables from bits 7 (buck A), 6 (buck B) and 5 (linear). Later ticks and power-good changes leave these enables unchanged.
- R8: `shdn_n` is high if and only if, for every regulator, its synchronized power-good is high or its effective mask is 1. A power-good change reaches `shdn_n` after two clocks.
- R9: The effective masks equal `fuse_mask` until the first write to address 0x04. From then on they equal bits 3 (buck A), 2 (buck B) and 1 (linear) of the last write. Reading 0x04 returns the effective masks in those bits, with the other bits zero.
- R10: Reading 0x03 returns the enables in bits 7, 6 and 5, the start bit in bit 4, and a busy flag in bit 0, with bits 3 to 1 zero. Busy is high from a start until the last used regulator reports power good, or until an abort or a manual write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin | input | 1 | Enable pin, synchronous to `clk`; rising edge starts, falling edge aborts |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| pg_in | input | 3 | Raw power-good per regulator (bit 0 buck A, 1 buck B, 2 linear) |
| fuse_order | input | 6 | Slot codes, two bits per slot, slot 0 in the low bits |
| fuse_unused | input | 3 | Regulator not fitted, skipped by the sequence |
| fuse_mask | input | 3 | Default power-good masks for `shdn_n` |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| reg_en | output | 3 | Regulator enables |
| shdn_n | output | 1 | High once all unmasked regulators are good |

## Verification
A slot pointer that skips a slot or lands on the wrong slot turns the wrong bit of `reg_en` on within three clocks of the tick that ends a wait. A gap counter that starts early or stops late moves that rise by one whole tick. Power-good gating that has been lost shows as an enable that rises while the previous regulator's power-good is still low, which the bench holds that way for many ticks. Faulty mask selection or a faulty combine shows on `shdn_n` two clocks after a power-good change, or in the very cycle of a write to 0x04.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  localparam int NREG = 3;
  localparam int CODE_W = 2;
  localparam logic [7:0] ADDR_CTRL = 8'h03;
  localparam logic [7:0] ADDR_OPC  = 8'h04;
  localparam logic [1:0] SLOT_EMPTY = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_ENABLE, ST_PGWAIT, ST_GAP, ST_DONE
  } seq_st_t;

  function automatic logic [1:0] slot_code(input logic [2*NREG-1:0] order,
                                           input logic [1:0] slot);
    logic [1:0] c;
    case (slot)
      2'd0:    c = order[1:0];
      2'd1:    c = order[3:2];
      default: c = order[5:4];
    endcase
    return c;
  endfunction

  function automatic logic release_ok(input logic [NREG-1:0] pg,
                                      input logic [NREG-1:0] mask);
    return &(pg | mask);
  endfunction

  function automatic logic [7:0] ctrl_word(input logic [NREG-1:0] en,
                                           input logic start_bit,
                                           input logic busy);
    return {en[0], en[1], en[2], start_bit, 3'b000, busy};
  endfunction

  function automatic logic [7:0] opc_word(input logic [NREG-1:0] mask);
    return {4'b0000, mask[0], mask[1], mask[2], 1'b0};
  endfunction
endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d_in[i];
        s2 <= s1;
      end
    end
    assign d_out[i] = s2;
  end
endmodule

// File: rtl/pwr_seq_regs.sv
module pwr_seq_regs
  import pwr_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_pin,
  input  logic            reg_wr,
  input  logic [7:0]      reg_addr,
  input  logic [7:0]      reg_wdata,
  input  logic [NREG-1:0] en_state,
  input  logic            busy,
  input  logic [NREG-1:0] fuse_mask,
  output logic            start_evt,
  output logic            abort_evt,
  output logic            manual_evt,
  output logic [NREG-1:0] manual_val,
  output logic [NREG-1:0] mask_eff,
  output logic [7:0]      reg_rdata
);
  logic            en_q, start_bit, ovr_seen;
  logic [NREG-1:0] mask_reg;
  logic            wr_ctrl, wr_opc, pin_rise, pin_fall;

  assign wr_ctrl    = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_opc     = reg_wr && (reg_addr == ADDR_OPC);
  assign pin_rise   = en_pin && !en_q;
  assign pin_fall   = !en_pin && en_q;
  assign abort_evt  = pin_fall;
  assign manual_evt = wr_ctrl && !reg_wdata[4];
  assign manual_val = {reg_wdata[5], reg_wdata[6], reg_wdata[7]};
  assign start_evt  = pin_rise || (wr_ctrl && reg_wdata[4] && !start_bit);
  assign mask_eff   = ovr_seen ? mask_reg : fuse_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      start_bit <= 1'b0;
      ovr_seen  <= 1'b0;
      mask_reg  <= '0;
    end else begin
      en_q <= en_pin;
      if (abort_evt || manual_evt)
        start_bit <= 1'b0;
      else if (wr_ctrl && reg_wdata[4])
        start_bit <= 1'b1;
      if (wr_opc) begin
        ovr_seen <= 1'b1;
        mask_reg <= {reg_wdata[1], reg_wdata[2], reg_wdata[3]};
      end
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_CTRL: reg_rdata = ctrl_word(en_state, start_bit, busy);
      ADDR_OPC:  reg_rdata = opc_word(mask_eff);
      default:   reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int STARTUP_TICKS = 5,
  parameter int GAP1_TICKS    = 2,
  parameter int GAP2_TICKS    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              abort_evt,
  input  logic              manual_evt,
  input  logic [NREG-1:0]   manual_val,
  input  logic              ms_tick,
  input  logic [NREG-1:0]   pg_s,
  input  logic [2*NREG-1:0] order,
  input  logic [NREG-1:0]   unused,
  output logic [NREG-1:0]   en,
  output logic              busy
);
  localparam int MAXG  = (GAP1_TICKS > GAP2_TICKS) ? GAP1_TICKS : GAP2_TICKS;
  localparam int MAXT  = (STARTUP_TICKS > MAXG) ? STARTUP_TICKS : MAXG;
  localparam int CW    = $clog2(MAXT + 1);

  seq_st_t       state;
  logic [1:0]    slot, code;
  logic [CW-1:0] cnt, limit;
  logic          slot_skip, last_slot, limit_hit;

  function automatic logic [CW-1:0] gap_last(input logic [1:0] s);
    return (s == 2'd0) ? CW'(GAP1_TICKS - 1) : CW'(GAP2_TICKS - 1);
  endfunction

  assign code      = slot_code(order, slot);
  assign slot_skip = (code == SLOT_EMPTY) ? 1'b1 : unused[code];
  assign last_slot = (slot == 2'd2);
  assign limit     = (state == ST_START) ? CW'(STARTUP_TICKS - 1) : gap_last(slot);
  assign limit_hit = ms_tick && (cnt == limit);
  assign busy      = (state != ST_IDLE) && (state != ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      en    <= '0;
      slot  <= 2'd0;
      cnt   <= '0;
    end else if (abort_evt) begin
      state <= ST_IDLE;
      en    <= '0;
    end else if (manual_evt) begin
      state <= ST_IDLE;
      en    <= manual_val;
    end else if (start_evt) begin
      state <= ST_START;
      en    <= '0;
      slot  <= 2'd0;
      cnt   <= '0;
    end else begin
      case (state)
        ST_START, ST_GAP: begin
          if (limit_hit) begin
            cnt   <= '0;
            state <= ST_ENABLE;
            if (state == ST_GAP) slot <= slot + 2'd1;
          end else if (ms_tick) begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_ENABLE: begin
          if (slot_skip) begin
            if (last_slot) state <= ST_DONE;
            else           slot  <= slot + 2'd1;
          end else begin
            en[code] <= 1'b1;
            state    <= ST_PGWAIT;
          end
        end
        ST_PGWAIT: begin
          if (pg_s[code]) begin
            cnt   <= '0;
            state <= last_slot ? ST_DONE : ST_GAP;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int STARTUP_TICKS = 5,
  parameter int GAP1_TICKS    = 2,
  parameter int GAP2_TICKS    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_pin,
  input  logic       ms_tick,
  input  logic [2:0] pg_in,
  input  logic [5:0] fuse_order,
  input  logic [2:0] fuse_unused,
  input  logic [2:0] fuse_mask,
  input  logic       reg_wr,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic [2:0] reg_en,
  output logic       shdn_n
);
  logic [NREG-1:0] pg_s, manual_val, mask_eff;
  logic            start_evt, abort_evt, manual_evt, busy;

  pwr_seq_sync #(.W(NREG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pg_in), .d_out(pg_s)
  );

  pwr_seq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .en_pin(en_pin),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .en_state(reg_en), .busy(busy), .fuse_mask(fuse_mask),
    .start_evt(start_evt), .abort_evt(abort_evt), .manual_evt(manual_evt),
    .manual_val(manual_val), .mask_eff(mask_eff), .reg_rdata(reg_rdata)
  );

  pwr_seq_fsm #(
    .STARTUP_TICKS(STARTUP_TICKS), .GAP1_TICKS(GAP1_TICKS), .GAP2_TICKS(GAP2_TICKS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .abort_evt(abort_evt),
    .manual_evt(manual_evt), .manual_val(manual_val), .ms_tick(ms_tick),
    .pg_s(pg_s), .order(fuse_order), .unused(fuse_unused),
    .en(reg_en), .busy(busy)
  );

  assign shdn_n = release_ok(pg_s, mask_eff);
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] en_vec,
  input logic       start_evt,
  input logic       abort_evt,
  input logic       manual_evt,
  input logic       busy,
  input logic [2:0] fuse_unused
);
  p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !manual_evt |=> ($countones(en_vec & ~$past(en_vec)) <= 1));

  p_abort_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (en_vec == 3'b000));

  p_start_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !abort_evt && !manual_evt) |=> (en_vec == 3'b000));

  p_unused_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !manual_evt |=> ((en_vec & ~$past(en_vec) & $past(fuse_unused)) == 3'b000));

  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !manual_evt && !start_evt && !abort_evt) |=> $stable(en_vec));
endmodule

bind pwr_seq_ctrl pwr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_vec(reg_en), .start_evt(start_evt),
  .abort_evt(abort_evt), .manual_evt(manual_evt), .busy(busy),
  .fuse_unused(fuse_unused)
);

// File: tb/pwr_seq_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_pin = 1'b0, ms_tick = 1'b0, reg_wr = 1'b0;
  logic [2:0] pg_in = 3'b000, fuse_unused = 3'b000, fuse_mask = 3'b000;
  logic [5:0] fuse_order = 6'b10_01_00;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [2:0] reg_en;
  logic       shdn_n;
  int         n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  pwr_seq_ctrl u_pwr_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .ms_tick(ms_tick), .pg_in(pg_in),
    .fuse_order(fuse_order), .fuse_unused(fuse_unused), .fuse_mask(fuse_mask),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_en(reg_en), .shdn_n(shdn_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
      settle(2);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; en_pin = 1'b0; pg_in = 3'b000; ms_tick = 1'b0; reg_wr = 1'b0;
    settle(3);
    rst_n = 1'b1;
    settle(2);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(8'h03, d);
    check("R10 reset ctrl read", d, 8'h00);
    check("R6 reset enables", {5'b0, reg_en}, 8'h00);
    check("R8 reset shdn_n", {7'b0, shdn_n}, 8'h00);
  endtask

  task automatic t_fuse_mask();
    logic [7:0] d;
    fuse_mask = 3'b101; pg_in = 3'b010;
    settle(4);
    check("R9 fuse masks used", {7'b0, shdn_n}, 8'h01);
    rd(8'h04, d);
    check("R9 opc read of fuse masks", d, 8'h0A);
    pg_in = 3'b000;
    settle(1);
    check("R8 two-clock pg latency", {7'b0, shdn_n}, 8'h01);
    settle(2);
    check("R8 unmasked pg low", {7'b0, shdn_n}, 8'h00);
    fuse_mask = 3'b000;
  endtask

  task automatic t_pin_seq();
    logic [7:0] d;
    @(negedge clk) en_pin = 1'b1;
    settle(2);
    ticks(4);
    check("R1 quiet before startup count", {5'b0, reg_en}, 8'h00);
    rd(8'h03, d);
    check("R10 busy during startup", d, 8'h01);
    ticks(1);
    check("R2 slot0 buck A first", {5'b0, reg_en}, 8'h01);
    ticks(10);
    check("R3 waits for pg before gap", {5'b0, reg_en}, 8'h01);
    pg_in[0] = 1'b1;
    settle(4);
    ticks(1);
    check("R3 gap1 not done after 1 tick", {5'b0, reg_en}, 8'h01);
    ticks(1);
    check("R3 slot1 buck B after gap1", {5'b0, reg_en}, 8'h03);
    pg_in[1] = 1'b1;
    settle(4);
    ticks(2);
    check("R3 gap2 not done after 2 ticks", {5'b0, reg_en}, 8'h03);
    ticks(1);
    check("R2 slot2 linear after gap2", {5'b0, reg_en}, 8'h07);
    rd(8'h03, d);
    check("R10 busy until last pg", d, 8'hE1);
    pg_in[2] = 1'b1;
    settle(4);
    rd(8'h03, d);
    check("R10 done clears busy", d, 8'hE0);
  endtask

  task automatic t_release();
    logic [7:0] d;
    check("R8 all good releases", {7'b0, shdn_n}, 8'h01);
    pg_in[1] = 1'b0;
    settle(4);
    check("R8 buck B pg low holds", {7'b0, shdn_n}, 8'h00);
    wr(8'h04, 8'h04);
    check("R9 register mask overrides", {7'b0, shdn_n}, 8'h01);
    rd(8'h04, d);
    check("R9 opc read of override", d, 8'h04);
  endtask

  task automatic t_pin_fall();
    logic [7:0] d;
    @(negedge clk) en_pin = 1'b0;
    settle(2);
    check("R6 pin fall drops enables", {5'b0, reg_en}, 8'h00);
    rd(8'h03, d);
    check("R6 ctrl after abort", d, 8'h00);
  endtask

  task automatic t_reg_start_order();
    logic [7:0] d;
    fuse_order = 6'b01_00_10;
    wr(8'h03, 8'h10);
    rd(8'h03, d);
    check("R5 start bit and busy set", d, 8'h11);
    ticks(5);
    check("R2 custom order linear first", {5'b0, reg_en}, 8'h04);
    wr(8'h03, 8'h10);
    check("R5 repeat start ignored", {5'b0, reg_en}, 8'h04);
    pg_in[2] = 1'b1;
    settle(4);
    ticks(2);
    check("R5 no restart, slot1 buck A", {5'b0, reg_en}, 8'h05);
    wr(8'h03, 8'h00);
    rd(8'h03, d);
    check("R7 clear start drops all", d, 8'h00);
    fuse_order = 6'b10_01_00;
  endtask

  task automatic t_unused();
    logic [7:0] d;
    fuse_unused = 3'b010;
    wr(8'h03, 8'h10);
    ticks(5);
    check("R4 slot0 enabled", {5'b0, reg_en}, 8'h01);
    pg_in[0] = 1'b1;
    settle(4);
    ticks(2);
    settle(2);
    check("R4 skip buck B without extra gap", {5'b0, reg_en}, 8'h05);
    ticks(6);
    check("R4 buck B stays off", {5'b0, reg_en}, 8'h05);
    rd(8'h03, d);
    check("R10 busy awaiting linear pg", d, 8'hB1);
    fuse_unused = 3'b000;
  endtask

  task automatic t_manual();
    logic [7:0] d;
    wr(8'h03, 8'h10);
    ticks(2);
    wr(8'h03, 8'h40);
    rd(8'h03, d);
    check("R7 manual write read back", d, 8'h40);
    ticks(8);
    pg_in = 3'b111;
    settle(4);
    check("R7 sequence halted by manual", {5'b0, reg_en}, 8'h02);
    wr(8'h03, 8'hA0);
    check("R7 manual buck A and linear", {5'b0, reg_en}, 8'h05);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_fuse_mask();
    t_pin_seq();
    t_release();
    t_pin_fall();
    do_reset();
    t_reg_start_order();
    do_reset();
    t_unused();
    do_reset();
    t_manual();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule